// File: doc/BRIEF.md
# Serial Converter Command Framer

This block is the device-side serial port of a four-channel, 10-bit converter operated from an external bit clock. The controller holds the select line low and clocks bits in on the serial input. The framer ignores leading zeros, takes the first 1 it sees while idle as the opening bit of an 8-bit command, and issues a one-cycle conversion request on the bit-clock falling edge after the eighth command bit. It then returns the converter result on the serial output, MSB first. Lowering the select line does not start a frame by itself.

A new command may begin while the previous result is still leaving the port, so frames can repeat every 15 or 16 bit clocks with select held low. Raising and lowering the select line abandons whatever is in flight. With select tied low, a run of 16 zeros always brings the port back to a state where the next 1 opens a command.

The serial clock, select and data inputs are oversampled by the 100 MHz system clock. All decisions are taken on detected bit-clock edges, and every output is a flop.

Top module: `adc_frame_if`

## Requirements
- R1: With ser_clk idle, lowering sel_n starts nothing. The first 1 sampled on a ser_clk rising edge while idle with sel_n low opens a command. cmd_byte[7] holds that opening 1 and bits 6..0 hold the next seven sampled bits in arrival order. cmd_byte updates only after the eighth bit arrives.
- R2: conv_req is a single system-clock pulse that follows the ser_clk falling edge after the eighth command bit.
- R3: On that falling edge ser_out drives 0. The next ten falling edges drive sample[9] down to sample[0], as captured at the request. Later falling edges drive 0.
- R4: A 1 sampled before the falling edge that drives result bit 3 has passed is ignored. A 1 sampled on any later rising edge opens a new command.
- R5: Raising sel_n abandons capture and readout. conv_done returns high and ser_out returns to 0. After sel_n falls again, the next 1 opens a command.
- R6: With sel_n held low, commands opened every 15 ser_clk cycles each produce a conversion.
- R7: With sel_n held low, commands opened every 16 ser_clk cycles each produce a conversion.
- R8: After any input history, 16 consecutive zeros on ser_in leave the port ready, so the next 1 opens a command.
- R9: After reset, conv_done is 1, ser_out is 0, conv_req is 0 and cmd_byte is 0.
- R10: ser_out_en is the registered inverse of sel_n. ser_out changes only after a ser_clk falling edge or while sel_n is high.
- R11: conv_done falls with the conversion request and rises on the falling edge that drives result bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ser_clk | input | 1 | Serial bit clock from the controller |
| sel_n | input | 1 | Active-low port select |
| ser_in | input | 1 | Serial command input |
| sample | input | RES_W | Converter result from the analog stub |
| ser_out | output | 1 | Serial result output |
| ser_out_en | output | 1 | Output enable for the serial output pad |
| conv_done | output | 1 | High when no conversion is in flight |
| conv_req | output | 1 | One-cycle conversion request |
| cmd_byte | output | CTRL_W | Last complete command byte |

## Verification
The bench builds the port with its default widths: an 8-bit command, a 10-bit result, and bit 3 as the overlap point. These values make the real 15-cycle and 16-cycle repeat rates reachable. They also place the overlap boundary at a fixed bit-clock position, so ones can be driven on the cycles just before and just after it. A bench model walks each input stream and predicts every ser_out bit, the conv_done level, the conversion count and the final command byte. Streams cover directed frames, back-to-back frames at both rates, aborts during capture and during readout, a 16-zero recovery after random noise, and random sparse traffic.

// File: rtl/adc_frm_pkg.sv
package adc_frm_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_ev_t;
endpackage

// File: rtl/sclk_edge.sv
module sclk_edge
  import adc_frm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_clk,
  output sclk_ev_t ev
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= ser_clk;
  end

  assign ev.rise = ser_clk & ~sclk_q;
  assign ev.fall = ~ser_clk & sclk_q;
endmodule

// File: rtl/ctrl_capture.sv
module ctrl_capture
  import adc_frm_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              ser_in,
  input  sclk_ev_t          ev,
  input  logic              accept_ok,
  output logic              fire,
  output logic [CTRL_W-1:0] cmd
);
  localparam int CNT_W = $clog2(CTRL_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [CTRL_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      fire   <= 1'b0;
      cmd    <= '0;
    end else if (sel_n) begin
      active <= 1'b0;
      cnt    <= '0;
      fire   <= 1'b0;
    end else begin
      if (ev.fall && fire) fire <= 1'b0;
      if (ev.rise) begin
        if (active) begin
          sh <= {sh[CTRL_W-2:0], ser_in};
          if (cnt == LAST) begin
            active <= 1'b0;
            cnt    <= '0;
            fire   <= 1'b1;
            cmd    <= {sh[CTRL_W-2:0], ser_in};
          end else begin
            cnt <= cnt + ONE;
          end
        end else if (ser_in && accept_ok && !fire) begin
          active <= 1'b1;
          cnt    <= ONE;
          sh     <= {{(CTRL_W-1){1'b0}}, 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/result_shifter.sv
module result_shifter
  import adc_frm_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int GUARD_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  sclk_ev_t         ev,
  input  logic             fire,
  input  logic [RES_W-1:0] sample,
  output logic             accept_ok,
  output logic             ser_out,
  output logic             conv_done,
  output logic             conv_req
);
  localparam int CW = $clog2(RES_W + 2);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] LASTB = CW'(RES_W);
  localparam logic [CW-1:0] OPEN  = CW'(RES_W - GUARD_BIT + 1);

  logic [CW-1:0]    rd_cnt;
  logic [RES_W-1:0] sh;

  assign accept_ok = (rd_cnt == '0) || (rd_cnt >= OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt    <= '0;
      sh        <= '0;
      ser_out   <= 1'b0;
      conv_done <= 1'b1;
      conv_req  <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      if (sel_n) begin
        rd_cnt    <= '0;
        ser_out   <= 1'b0;
        conv_done <= 1'b1;
      end else if (ev.fall) begin
        if (fire) begin
          sh        <= sample;
          ser_out   <= 1'b0;
          rd_cnt    <= ONE;
          conv_done <= 1'b0;
          conv_req  <= 1'b1;
        end else if (rd_cnt >= ONE && rd_cnt <= LASTB) begin
          ser_out <= sh[RES_W-1];
          sh      <= {sh[RES_W-2:0], 1'b0};
          rd_cnt  <= rd_cnt + ONE;
          if (rd_cnt == LASTB) conv_done <= 1'b1;
        end else begin
          ser_out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_if.sv
module adc_frame_if
  import adc_frm_pkg::*;
#(
  parameter int CTRL_W    = 8,
  parameter int RES_W     = 10,
  parameter int GUARD_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              sel_n,
  input  logic              ser_in,
  input  logic [RES_W-1:0]  sample,
  output logic              ser_out,
  output logic              ser_out_en,
  output logic              conv_done,
  output logic              conv_req,
  output logic [CTRL_W-1:0] cmd_byte
);
  sclk_ev_t ev;
  logic     fire;
  logic     accept_ok;

  sclk_edge i_edge (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ev(ev)
  );

  ctrl_capture #(.CTRL_W(CTRL_W)) i_cap (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ser_in(ser_in), .ev(ev),
    .accept_ok(accept_ok), .fire(fire), .cmd(cmd_byte)
  );

  result_shifter #(.RES_W(RES_W), .GUARD_BIT(GUARD_BIT)) i_shf (
    .clk(clk), .rst(rst), .sel_n(sel_n), .ev(ev), .fire(fire),
    .sample(sample), .accept_ok(accept_ok), .ser_out(ser_out),
    .conv_done(conv_done), .conv_req(conv_req)
  );

  always_ff @(posedge clk) begin
    if (rst) ser_out_en <= 1'b0;
    else     ser_out_en <= ~sel_n;
  end
endmodule

// File: rtl/adc_frame_if_chk.sv
module adc_frame_if_chk #(
  parameter int CTRL_W = 8,
  parameter int RES_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_clk,
  input logic              sel_n,
  input logic              ser_in,
  input logic [RES_W-1:0]  sample,
  input logic              ser_out,
  input logic              ser_out_en,
  input logic              conv_done,
  input logic              conv_req,
  input logic [CTRL_W-1:0] cmd_byte
);
  p_cmd_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_byte) |-> ($past(ser_clk) && !$past(ser_clk, 2)));

  p_req_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> (!$past(ser_clk) && $past(ser_clk, 2)));

  p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  p_done_low_r11: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> !conv_done);

  p_out_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_out) |-> ((!$past(ser_clk) && $past(ser_clk, 2)) || $past(sel_n)));

  p_deselect_idle_r5: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> (!ser_out_en && conv_done && !ser_out));
endmodule

bind adc_frame_if adc_frame_if_chk #(.CTRL_W(CTRL_W), .RES_W(RES_W)) i_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
  .sample(sample), .ser_out(ser_out), .ser_out_en(ser_out_en),
  .conv_done(conv_done), .conv_req(conv_req), .cmd_byte(cmd_byte)
);

// File: tb/test_adc_frame_if.sv
module test_adc_frame_if;
  localparam int HP = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       sel_n = 1'b1;
  logic       ser_in = 1'b0;
  logic [9:0] sample = '0;
  logic       ser_out, ser_out_en, conv_done, conv_req;
  logic [7:0] cmd_byte;

  int tests = 0;
  int fails = 0;
  int conv_seen = 0;
  int last_nconv;
  logic [7:0] exp_cmd = '0;
  bit ds [0:127];

  always #5 clk = ~clk;

  adc_frame_if i_adc_frame_if (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .sel_n(sel_n), .ser_in(ser_in),
    .sample(sample), .ser_out(ser_out), .ser_out_en(ser_out_en),
    .conv_done(conv_done), .conv_req(conv_req), .cmd_byte(cmd_byte)
  );

  always @(posedge clk) if (!rst && conv_req) conv_seen <= conv_seen + 1;

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Model: a 1 at cycle s opens a command when s >= avail; request on fall s+7,
  // result MSB on fall s+8, bit 3 on fall s+14, next start accepted from s+15.
  task automatic run_stream(input int n, input string tag);
    bit ed [0:127];
    bit es [0:127];
    int avail = 0;
    int nconv = 0;
    int base;
    for (int c = 0; c < 128; c++) begin ed[c] = 1'b0; es[c] = 1'b1; end
    for (int c = 0; c < n; c++) begin
      if (c >= avail && ds[c]) begin
        avail = c + 15;
        if (c + 7 < n) begin
          nconv++;
          for (int k = 0; k < 8; k++) exp_cmd[7-k] = ds[c+k];
          for (int k = 7; k < 17 && c + k < n; k++) es[c+k] = 1'b0;
          for (int j = 0; j < 10 && c + 8 + j < n; j++) ed[c+8+j] = sample[9-j];
        end
      end
    end
    last_nconv = nconv;
    sel_n = 1'b0;
    tick(2);
    chk(ser_out_en == 1'b1, {"R10 enable ", tag}, ser_out_en, 1);
    base = conv_seen;
    for (int c = 0; c < n; c++) begin
      ser_in = ds[c];
      tick(HP);
      if (c == 0) begin
        chk(ser_out == 1'b0, {"R3 first ", tag}, ser_out, 0);
      end else begin
        chk(ser_out == ed[c-1], {"R3 R4 out ", tag}, ser_out, ed[c-1]);
        chk(conv_done == es[c-1], {"R11 done ", tag}, conv_done, es[c-1]);
      end
      ser_clk = 1'b1;
      tick(HP);
      ser_clk = 1'b0;
    end
    tick(HP);
    chk(ser_out == ed[n-1], {"R3 R4 out ", tag}, ser_out, ed[n-1]);
    chk(conv_done == es[n-1], {"R11 done ", tag}, conv_done, es[n-1]);
    chk(conv_seen - base == nconv, {"R2 count ", tag}, conv_seen - base, nconv);
    chk(cmd_byte == exp_cmd, {"R1 cmd ", tag}, cmd_byte, exp_cmd);
    ser_in = 1'b0;
    sel_n = 1'b1;
    tick(2);
    chk(ser_out_en == 1'b0, {"R10 disable ", tag}, ser_out_en, 0);
    chk(conv_done == 1'b1 && ser_out == 1'b0, {"R5 deselect ", tag}, conv_done, 1);
  endtask

  task automatic clear_ds();
    for (int c = 0; c < 128; c++) ds[c] = 1'b0;
  endtask

  task automatic put_cmd(input int at);
    ds[at] = 1'b1;
    for (int k = 1; k < 8; k++) ds[at+k] = 1'($urandom % 2);
  endtask

  initial begin
    int base;
    logic [7:0] keep;
    void'($urandom(32'd4711));
    tick(4);
    rst = 1'b0;
    tick(2);
    // R9 reset state
    chk(conv_done == 1'b1, "R9 conv_done", conv_done, 1);
    chk(ser_out == 1'b0, "R9 ser_out", ser_out, 0);
    chk(conv_req == 1'b0, "R9 conv_req", conv_req, 0);
    chk(cmd_byte == 8'h00, "R9 cmd_byte", cmd_byte, 0);

    // R1: select low with ser_in high and no clock edges starts nothing
    base = conv_seen;
    sel_n = 1'b0; ser_in = 1'b1;
    tick(30);
    chk(conv_seen == base, "R1 no edges", conv_seen - base, 0);
    ser_in = 1'b0; sel_n = 1'b1; tick(2);

    clear_ds();
    run_stream(12, "R1 zeros");

    sample = 10'h2B5;
    clear_ds(); put_cmd(3);
    run_stream(26, "R1 R2 R3 single");

    // R4: ones during early readout ignored, first legal slot accepted
    sample = 10'h19C;
    clear_ds(); put_cmd(0);
    for (int c = 8; c < 15; c++) ds[c] = 1'b1;
    put_cmd(15);
    run_stream(40, "R4 overlap");
    chk(last_nconv == 2, "R4 two frames", last_nconv, 2);

    // R6: 15-cycle frames, noise in ignored slots
    sample = 10'h3C3;
    clear_ds();
    for (int f = 0; f < 4; f++) begin
      put_cmd(f * 15);
      for (int k = 8; k < 15; k++) ds[f*15+k] = 1'($urandom % 2);
    end
    run_stream(78, "R6 rate15");
    chk(last_nconv == 4, "R6 frames", last_nconv, 4);

    // R7: 16-cycle frames
    sample = 10'h0F1;
    clear_ds();
    for (int f = 0; f < 4; f++) begin
      put_cmd(f * 16);
      for (int k = 8; k < 15; k++) ds[f*16+k] = 1'($urandom % 2);
    end
    run_stream(82, "R7 rate16");
    chk(last_nconv == 4, "R7 frames", last_nconv, 4);

    // R5: abort mid readout, then abort mid capture
    sample = 10'h155;
    clear_ds(); put_cmd(0);
    run_stream(13, "R5 abort read");
    sample = 10'h2AA;
    clear_ds(); put_cmd(0);
    run_stream(26, "R5 after abort");
    clear_ds(); ds[0] = 1'b1; ds[1] = 1'b1; ds[2] = 1'b1;
    keep = exp_cmd;
    run_stream(4, "R5 abort cap");
    chk(cmd_byte == keep, "R5 cmd kept", cmd_byte, keep);
    clear_ds(); put_cmd(0); ds[1] = 1'b0;
    run_stream(20, "R5 fresh cmd");

    // R8: noise, 16 zeros, then a command
    sample = 10'h37E;
    clear_ds();
    for (int c = 0; c < 20; c++) ds[c] = 1'($urandom % 2);
    put_cmd(36);
    keep = {ds[36], ds[37], ds[38], ds[39], ds[40], ds[41], ds[42], ds[43]};
    run_stream(56, "R8 resync");
    chk(cmd_byte == keep, "R8 cmd after zeros", cmd_byte, keep);

    for (int r = 0; r < 6; r++) begin
      sample = 10'($urandom);
      clear_ds();
      for (int c = 0; c < 70; c++) ds[c] = (($urandom % 3) == 0);
      run_stream(70, "R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule